// File: doc/BRIEF.md
# Partition-Bounded Sliding Mask Register

This block holds a 64-bit mask word used to select which bit positions take part in a search. Software loads the whole word in one cycle. The word is read continuously on the output. Two single-cycle strobes then grow the masked region one bit at a time, toward the low end or toward the high end.

A shift never moves bits around the end of the field. The edge bit of the field is copied into its neighbour, so repeated shifts spread a pattern outward like a sign extension.

The active field is the part of each word that holds searchable content. It is chosen by a 3-bit partition code. The code places a data-only region of whole 16-bit segments either at the low end or at the high end of the word. Bits in that region never move during a shift. A reset clears the word to all zeros, which means no bit position is excluded.

Top module: `slideMask`

## Requirements
- R1: While `rstN` is low, `maskOut` is all zeros.
- R2: When `loadEn` is high at a rising clock edge, `maskOut` equals `loadData` after that edge.
- R3: A load wins over either shift strobe asserted in the same cycle; the shift is dropped.
- R4: `partCode` selects the field as follows. 0 and 7 give bits 63..0. 1, 2 and 3 give bits 63..16, 63..32 and 63..48. 4, 5 and 6 give bits 47..0, 31..0 and 15..0. The field's upper limit bit is its highest bit and its lower limit bit is its lowest bit.
- R5: On a shift right (`shiftRight` high, `shiftLeft` low, no load), every field bit below the upper limit takes the old value of the bit one place above it. The upper limit bit keeps its value. The old lower limit bit is lost and does not reappear anywhere.
- R6: On a shift left (`shiftLeft` high, `shiftRight` low, no load), every field bit above the lower limit takes the old value of the bit one place below it. The lower limit bit keeps its value. The old upper limit bit is lost and does not reappear anywhere.
- R7: Bits outside the field never change on a shift.
- R8: With no load, and with both shift strobes high or both low, `maskOut` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| loadEn | input | 1 | Load strobe for the whole word |
| loadData | input | 64 | Word to load |
| shiftRight | input | 1 | Shift toward bit 0 by one place |
| shiftLeft | input | 1 | Shift toward bit 63 by one place |
| partCode | input | 3 | Field partition code |
| maskOut | output | 64 | Current mask word |

## Verification
The shift assertions compare each result with the word, field and limit selects of the previous cycle. They therefore assume that `partCode` is a known value at every clock edge after reset, and that the strobes are never X. The stimulus holds `partCode` steady across every load-and-shift pair, and changes it only while no shift is pending. All inputs are driven low during reset, so no property is evaluated against undefined values.

// File: rtl/slideMaskPkg.sv
package slideMaskPkg;

  // decoded per-cycle command from the control to the datapath
  typedef struct packed {
    logic load;
    logic shiftDn;
    logic shiftUp;
  } maskCmd_t;

  // partition codes: where the data-only segments sit
  typedef enum logic [2:0] {
    PART_FULL   = 3'd0,
    PART_LO1    = 3'd1,
    PART_LO2    = 3'd2,
    PART_LO3    = 3'd3,
    PART_HI1    = 3'd4,
    PART_HI2    = 3'd5,
    PART_HI3    = 3'd6,
    PART_FULL_B = 3'd7
  } partCode_e;

endpackage

// File: rtl/slideMaskCtl.sv
module slideMaskCtl
  import slideMaskPkg::*;
#(
  parameter int WIDTH = 64,
  parameter int SEG_W = 16
) (
  input  logic             loadEn,
  input  logic             shiftRight,
  input  logic             shiftLeft,
  input  logic [2:0]       partCode,
  output maskCmd_t         cmd,
  output logic [WIDTH-1:0] fieldMask,
  output logic [WIDTH-1:0] hiSel,
  output logic [WIDTH-1:0] loSel
);

  localparam int NSEG = WIDTH / SEG_W;

  logic [2:0] ramDepth;   // segments given to data-only storage
  logic       ramAtLow;   // data-only region at the low end
  logic [NSEG-1:0] segIn;
  logic [NSEG-1:0] segTop;
  logic [NSEG-1:0] segBot;

  // command decode: load first, contradictory shifts cancel
  always_comb begin
    cmd.load    = loadEn;
    cmd.shiftDn = !loadEn && shiftRight && !shiftLeft;
    cmd.shiftUp = !loadEn && shiftLeft && !shiftRight;
  end

  // partition decode
  always_comb begin
    ramAtLow = 1'b1;
    ramDepth = 3'd0;
    case (partCode_e'(partCode))
      PART_LO1: ramDepth = 3'd1;
      PART_LO2: ramDepth = 3'd2;
      PART_LO3: ramDepth = 3'd3;
      PART_HI1: begin ramAtLow = 1'b0; ramDepth = 3'd1; end
      PART_HI2: begin ramAtLow = 1'b0; ramDepth = 3'd2; end
      PART_HI3: begin ramAtLow = 1'b0; ramDepth = 3'd3; end
      default:  ramDepth = 3'd0;
    endcase
    if (int'(ramDepth) > NSEG - 1) ramDepth = 3'(NSEG - 1);
  end

  // per segment: membership and limit position
  for (genvar s = 0; s < NSEG; s++) begin : gSeg
    always_comb begin
      if (ramAtLow) segIn[s] = (s >= int'(ramDepth));
      else          segIn[s] = (s < NSEG - int'(ramDepth));
    end
    if (s == NSEG - 1) begin : gTopEdge
      assign segTop[s] = segIn[s];
    end else begin : gTopMid
      assign segTop[s] = segIn[s] && !segIn[s+1];
    end
    if (s == 0) begin : gBotEdge
      assign segBot[s] = segIn[s];
    end else begin : gBotMid
      assign segBot[s] = segIn[s] && !segIn[s-1];
    end
  end

  // expand segment flags to bit selects
  for (genvar i = 0; i < WIDTH; i++) begin : gBit
    localparam int SEG_IX = i / SEG_W;
    localparam int OFS    = i % SEG_W;
    assign fieldMask[i] = segIn[SEG_IX];
    if (OFS == SEG_W - 1) begin : gHi
      assign hiSel[i] = segTop[SEG_IX];
    end else begin : gHiNo
      assign hiSel[i] = 1'b0;
    end
    if (OFS == 0) begin : gLo
      assign loSel[i] = segBot[SEG_IX];
    end else begin : gLoNo
      assign loSel[i] = 1'b0;
    end
  end

endmodule

// File: rtl/slideMaskPath.sv
module slideMaskPath
  import slideMaskPkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  maskCmd_t         cmd,
  input  logic [WIDTH-1:0] loadData,
  input  logic [WIDTH-1:0] fieldMask,
  input  logic [WIDTH-1:0] hiSel,
  input  logic [WIDTH-1:0] loSel,
  output logic [WIDTH-1:0] maskQ
);

  logic [WIDTH-1:0] dnVal;
  logic [WIDTH-1:0] upVal;
  logic [WIDTH-1:0] nextVal;

  for (genvar i = 0; i < WIDTH; i++) begin : gCell
    // shift toward bit 0: take from above unless this is the upper limit
    if (i == WIDTH - 1) begin : gDnTop
      assign dnVal[i] = maskQ[i];
    end else begin : gDnMid
      assign dnVal[i] = (fieldMask[i] && !hiSel[i]) ? maskQ[i+1] : maskQ[i];
    end
    // shift toward the top bit: take from below unless this is the lower limit
    if (i == 0) begin : gUpBot
      assign upVal[i] = maskQ[i];
    end else begin : gUpMid
      assign upVal[i] = (fieldMask[i] && !loSel[i]) ? maskQ[i-1] : maskQ[i];
    end
  end

  always_comb begin
    nextVal = maskQ;
    if (cmd.load)         nextVal = loadData;
    else if (cmd.shiftDn) nextVal = dnVal;
    else if (cmd.shiftUp) nextVal = upVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) maskQ <= '0;
    else       maskQ <= nextVal;
  end

endmodule

// File: rtl/slideMask.sv
module slideMask
  import slideMaskPkg::*;
#(
  parameter int WIDTH = 64,
  parameter int SEG_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadEn,
  input  logic [WIDTH-1:0] loadData,
  input  logic             shiftRight,
  input  logic             shiftLeft,
  input  logic [2:0]       partCode,
  output logic [WIDTH-1:0] maskOut
);

  maskCmd_t         cmd;
  logic [WIDTH-1:0] fieldMask;
  logic [WIDTH-1:0] hiSel;
  logic [WIDTH-1:0] loSel;

  slideMaskCtl #(.WIDTH(WIDTH), .SEG_W(SEG_W)) i_ctl (
    .loadEn     (loadEn),
    .shiftRight (shiftRight),
    .shiftLeft  (shiftLeft),
    .partCode   (partCode),
    .cmd        (cmd),
    .fieldMask  (fieldMask),
    .hiSel      (hiSel),
    .loSel      (loSel)
  );

  slideMaskPath #(.WIDTH(WIDTH)) i_path (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .loadData  (loadData),
    .fieldMask (fieldMask),
    .hiSel     (hiSel),
    .loSel     (loSel),
    .maskQ     (maskOut)
  );

endmodule

// File: rtl/slideMaskChk.sv
module slideMaskChk #(
  parameter int WIDTH = 64
) (
  input logic             clk,
  input logic             rstN,
  input logic             loadEn,
  input logic [WIDTH-1:0] loadData,
  input logic             shiftRight,
  input logic             shiftLeft,
  input logic [WIDTH-1:0] maskOut,
  input logic [WIDTH-1:0] fieldMask,
  input logic [WIDTH-1:0] hiSel,
  input logic [WIDTH-1:0] loSel
);

  logic doDn;
  logic doUp;
  assign doDn = !loadEn && shiftRight && !shiftLeft;
  assign doUp = !loadEn && shiftLeft && !shiftRight;

  AST_RESET_CLEAR: assert property (@(posedge clk) !rstN |-> maskOut == '0); // R1

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> maskOut == $past(loadData)); // R2

  AST_LOAD_OVER_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    (loadEn && (shiftRight || shiftLeft)) |=> maskOut == $past(loadData)); // R3

  AST_LIMITS_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(hiSel) && $onehot(loSel) && ((hiSel | loSel) & ~fieldMask) == '0); // R4

  AST_DN_TOP_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    doDn |=> (maskOut & $past(hiSel)) == ($past(maskOut) & $past(hiSel))); // R5

  AST_DN_MOVE: assert property (@(posedge clk) disable iff (!rstN)
    doDn |=> (maskOut & $past(fieldMask & ~hiSel)) ==
             (($past(maskOut) >> 1) & $past(fieldMask & ~hiSel))); // R5

  AST_UP_BOT_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    doUp |=> (maskOut & $past(loSel)) == ($past(maskOut) & $past(loSel))); // R6

  AST_UP_MOVE: assert property (@(posedge clk) disable iff (!rstN)
    doUp |=> (maskOut & $past(fieldMask & ~loSel)) ==
             (($past(maskOut) << 1) & $past(fieldMask & ~loSel))); // R6

  AST_OUTSIDE_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    (!loadEn && (shiftRight || shiftLeft)) |=>
      (maskOut & ~$past(fieldMask)) == ($past(maskOut) & ~$past(fieldMask))); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!loadEn && (shiftRight == shiftLeft)) |=> $stable(maskOut)); // R8

endmodule

bind slideMask slideMaskChk #(.WIDTH(WIDTH)) i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .loadEn     (loadEn),
  .loadData   (loadData),
  .shiftRight (shiftRight),
  .shiftLeft  (shiftLeft),
  .maskOut    (maskOut),
  .fieldMask  (fieldMask),
  .hiSel      (hiSel),
  .loSel      (loSel)
);

// File: tb/test_slideMask.sv
module test_slideMask;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadEn = 1'b0;
  logic [63:0] loadData = '0;
  logic        shiftRight = 1'b0;
  logic        shiftLeft = 1'b0;
  logic [2:0]  partCode = '0;
  logic [63:0] maskOut;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  slideMask i_slideMask (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadData(loadData),
    .shiftRight(shiftRight), .shiftLeft(shiftLeft),
    .partCode(partCode), .maskOut(maskOut)
  );

  // op: 0 none, 1 right, 2 left, 3 both
  localparam int NV = 12;
  localparam logic [2:0]  vCode [NV] = '{3'd0, 3'd0, 3'd1, 3'd1, 3'd3, 3'd6,
                                         3'd4, 3'd5, 3'd7, 3'd2, 3'd2, 3'd0};
  localparam logic [1:0]  vOp   [NV] = '{2'd1, 2'd2, 2'd1, 2'd2, 2'd1, 2'd2,
                                         2'd1, 2'd2, 2'd3, 2'd1, 2'd2, 2'd0};
  localparam logic [63:0] vLoad [NV] = '{
    64'h8000_0000_0000_0001, 64'h8000_0000_0000_0001,
    64'hF000_0000_0001_1234, 64'h0000_0000_0001_5555,
    64'h8001_ABCD_0000_0000, 64'hFFFF_0000_0000_8001,
    64'h1234_8000_0000_0001, 64'hAAAA_AAAA_4000_0001,
    64'h0123_4567_89AB_CDEF, 64'h0000_0001_FFFF_FFFF,
    64'h8000_0000_0000_0000, 64'h0000_0000_0000_0005};
  localparam logic [63:0] vExp  [NV] = '{
    64'hC000_0000_0000_0000, 64'h0000_0000_0000_0003,
    64'hF800_0000_0000_1234, 64'h0000_0000_0003_5555,
    64'hC000_ABCD_0000_0000, 64'hFFFF_0000_0000_0003,
    64'h1234_C000_0000_0000, 64'hAAAA_AAAA_8000_0003,
    64'h0123_4567_89AB_CDEF, 64'h0000_0000_FFFF_FFFF,
    64'h0000_0000_0000_0000, 64'h0000_0000_0000_0005};
  localparam string vReq [NV] = '{"R5", "R6", "R5 R7", "R6 R7", "R5 R4", "R6 R4",
                                  "R5 R7", "R6 R7", "R8", "R5 R7", "R6 R7", "R8"};

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: maskOut=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doLoad(input logic [2:0] code, input logic [63:0] val);
    @(negedge clk);
    partCode = code; loadEn = 1'b1; loadData = val;
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  task automatic doOp(input logic [1:0] op);
    shiftRight = op[0]; shiftLeft = op[1];
    @(negedge clk);
    shiftRight = 1'b0; shiftLeft = 1'b0;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", maskOut, 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", maskOut, 64'h0);

    // vector table
    for (int k = 0; k < NV; k++) begin
      doLoad(vCode[k], vLoad[k]);
      check("R2 load", maskOut, vLoad[k]);
      doOp(vOp[k]);
      check(vReq[k], maskOut, vExp[k]);
    end

    // R3: load with shift strobes in the same cycle
    doLoad(3'd0, 64'h0000_0000_0000_0001);
    @(negedge clk);
    loadEn = 1'b1; loadData = 64'h0000_0000_0000_1234; shiftRight = 1'b1; shiftLeft = 1'b0;
    @(negedge clk);
    loadEn = 1'b0; shiftRight = 1'b0;
    check("R3 load over right", maskOut, 64'h0000_0000_0000_1234);
    loadEn = 1'b1; loadData = 64'h8000_0000_0000_0000; shiftLeft = 1'b1;
    @(negedge clk);
    loadEn = 1'b0; shiftLeft = 1'b0;
    check("R3 load over left", maskOut, 64'h8000_0000_0000_0000);

    // R5: repeated right shifts fill the whole field, then saturate
    for (int n = 1; n <= 64; n++) begin
      doOp(2'd1);
      if (n == 16) check("R5 sixteen shifts", maskOut, 64'hFFFF_8000_0000_0000);
    end
    check("R5 saturated", maskOut, 64'hFFFF_FFFF_FFFF_FFFF);

    // R6 and R7: repeated left shifts in field 31..0, RAM half kept
    doLoad(3'd5, 64'h5A5A_5A5A_0000_0001);
    for (int n = 0; n < 40; n++) doOp(2'd2);
    check("R6 R7 left fill", maskOut, 64'h5A5A_5A5A_FFFF_FFFF);

    // R8: idle cycles hold
    repeat (3) @(negedge clk);
    check("R8 idle", maskOut, 64'h5A5A_5A5A_FFFF_FFFF);

    // R1: reset in mid-run clears the word
    rstN = 1'b0;
    @(negedge clk);
    check("R1 mid reset", maskOut, 64'h0);
    rstN = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule